// File: doc/BRIEF.md
# Byte-Command JTAG Pin Driver

This block sits between a byte stream, typically from a serial receiver, and the pins of an external JTAG test access port. Each accepted byte is one command. The block decodes the byte and then does one of the following: it changes the clock, mode-select and data-in pin levels, it samples the TAP data-out pin and returns an ASCII digit, it pulses the TAP reset, it switches an indicator LED, or it ends the session. Commands are applied strictly in arrival order, one byte per accepted transfer.

Input and reply both use a byte-wide valid/ready handshake. The reply path holds a single byte. A read command is held back while a reply is waiting and the reply output is stalled, so no reply byte can be lost. After the quit command, further bytes are still taken from the input but are discarded. This continues until a new-session strobe arrives.

Top module: `bitbang_cmd_decoder`

## Requirements
- R1: An accepted byte 0x30..0x37 ('0'..'7') sets the pins from its low three bits: bit 2 to tckO, bit 1 to tmsO and bit 0 to tdiO. The new levels are visible from the clock edge that accepts the byte.
- R2: After reset, tckO, tmsO, tdiO, ledO, outValid, tapRstO, badCmd and sessionDone are all 0. The pin levels hold their last value until another digit command is accepted.
- R3: An accepted 0x52 ('R') loads the reply register at the accepting edge with 0x31 ('1') when tdoI is high at that edge, or 0x30 ('0') when it is low, and sets outValid. The reply leaves when outValid and outReady are both high at an edge.
- R4: An accepted 0x72 ('r') sets tapRstO high for exactly one clock cycle and leaves the pins unchanged.
- R5: While outValid is high and outReady is low, a pending 0x52 is not accepted (inReady low), and outData and outValid hold. Other commands are still accepted.
- R6: An accepted 0x51 ('Q') sets sessionDone. While sessionDone is high, inReady is high and every byte is discarded without effect on pins, LED, reply, tapRstO or badCmd. A newSession pulse clears sessionDone.
- R7: An accepted 0x42 ('B') sets ledO and 0x62 ('b') clears it. Neither changes the pins.
- R8: An accepted byte that is none of the above raises badCmd for exactly one cycle per such byte and changes nothing else.
- R9: Bytes are executed in acceptance order, one command per accepted transfer, with back-to-back transfers allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Command byte |
| inValid | input | 1 | Command byte present |
| inReady | output | 1 | Command byte taken this cycle when inValid is high |
| outData | output | 8 | Reply byte, ASCII '0' or '1' |
| outValid | output | 1 | Reply byte present |
| outReady | input | 1 | Reply consumer can take the byte |
| newSession | input | 1 | Clears the session-ended state |
| tdoI | input | 1 | TAP data-out pin |
| tckO | output | 1 | TAP clock pin level |
| tmsO | output | 1 | TAP mode-select pin level |
| tdiO | output | 1 | TAP data-in pin level |
| tapRstO | output | 1 | One-cycle TAP reset pulse |
| sessionDone | output | 1 | Session ended by quit command |
| ledO | output | 1 | Indicator LED |
| badCmd | output | 1 | One-cycle unsupported-command flag |

## Verification
The case hardest to reach from the ports is a read command that meets a full, stalled reply register. In the same cycle the stall lifts, the old reply drains and the new one loads. The stimulus holds outReady low, reads once, and presents a second read while TDO has changed. It checks that inReady stays low and the first digit holds. It then raises outReady and expects the second digit to replace the first without a gap in outValid. Every one of the 256 byte values is also swept from a known pin state, with the expected pins, LED, pulse flags and reply computed from the byte's bits.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int BYTE_W = 8;
  localparam int PIN_W  = 3;

  localparam logic [BYTE_W-1:0] CH_ZERO   = 8'h30;
  localparam logic [BYTE_W-1:0] CH_ONE    = 8'h31;
  localparam logic [BYTE_W-1:0] CH_READ   = 8'h52;
  localparam logic [BYTE_W-1:0] CH_RST    = 8'h72;
  localparam logic [BYTE_W-1:0] CH_QUIT   = 8'h51;
  localparam logic [BYTE_W-1:0] CH_LEDON  = 8'h42;
  localparam logic [BYTE_W-1:0] CH_LEDOFF = 8'h62;
  // digits '0'..'7' share this upper bit pattern
  localparam logic [BYTE_W-PIN_W-1:0] DIGIT_HI = CH_ZERO[BYTE_W-1:PIN_W];

  typedef enum logic [2:0] {
    CMD_PINS, CMD_READ, CMD_RST, CMD_QUIT, CMD_LEDON, CMD_LEDOFF, CMD_BAD
  } bb_cmd_e;

  typedef struct packed {
    logic             loadPins;
    logic [PIN_W-1:0] pinLevels;
    logic             pushReply;
    logic             ledOn;
    logic             ledOff;
    logic             tapRst;
    logic             badCmd;
  } bb_strobe_t;
endpackage

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              replyStalled,
  input  logic              newSession,
  output logic              inReady,
  output logic              sessionDone,
  output bb_strobe_t        strobe
);
  bb_cmd_e cmd;
  logic    take;

  function automatic bb_cmd_e classify(input logic [BYTE_W-1:0] b);
    if (b[BYTE_W-1:PIN_W] == DIGIT_HI) return CMD_PINS;
    case (b)
      CH_READ:   return CMD_READ;
      CH_RST:    return CMD_RST;
      CH_QUIT:   return CMD_QUIT;
      CH_LEDON:  return CMD_LEDON;
      CH_LEDOFF: return CMD_LEDOFF;
      default:   return CMD_BAD;
    endcase
  endfunction

  always_comb begin
    cmd     = classify(inData);
    // after quit everything is drained; a read waits for reply room
    inReady = sessionDone | ~((cmd == CMD_READ) & replyStalled);
    take    = inValid & inReady & ~sessionDone;
    strobe.loadPins  = take & (cmd == CMD_PINS);
    strobe.pinLevels = inData[PIN_W-1:0];
    strobe.pushReply = take & (cmd == CMD_READ);
    strobe.ledOn     = take & (cmd == CMD_LEDON);
    strobe.ledOff    = take & (cmd == CMD_LEDOFF);
    strobe.tapRst    = take & (cmd == CMD_RST);
    strobe.badCmd    = take & (cmd == CMD_BAD);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         sessionDone <= 1'b0;
    else if (newSession)               sessionDone <= 1'b0;
    else if (take && cmd == CMD_QUIT)  sessionDone <= 1'b1;
  end
endmodule

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bb_strobe_t        strobe,
  input  logic              tdoI,
  input  logic              outReady,
  output logic [PIN_W-1:0]  pins,
  output logic              tapRstO,
  output logic              ledO,
  output logic              badCmd,
  output logic [BYTE_W-1:0] outData,
  output logic              outValid,
  output logic              replyStalled
);
  for (genvar g = 0; g < PIN_W; g++) begin : gPin
    always_ff @(posedge clk) begin
      if (!rstN)               pins[g] <= 1'b0;
      else if (strobe.loadPins) pins[g] <= strobe.pinLevels[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tapRstO <= 1'b0;
      badCmd  <= 1'b0;
      ledO    <= 1'b0;
    end else begin
      tapRstO <= strobe.tapRst;
      badCmd  <= strobe.badCmd;
      if (strobe.ledOn)       ledO <= 1'b1;
      else if (strobe.ledOff) ledO <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= CH_ZERO;
    end else if (strobe.pushReply) begin
      outValid <= 1'b1;
      outData  <= tdoI ? CH_ONE : CH_ZERO;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  assign replyStalled = outValid & ~outReady;
endmodule

// File: rtl/bitbang_cmd_decoder.sv
module bitbang_cmd_decoder
  import bb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inData,
  input  logic       inValid,
  output logic       inReady,
  output logic [7:0] outData,
  output logic       outValid,
  input  logic       outReady,
  input  logic       newSession,
  input  logic       tdoI,
  output logic       tckO,
  output logic       tmsO,
  output logic       tdiO,
  output logic       tapRstO,
  output logic       sessionDone,
  output logic       ledO,
  output logic       badCmd
);
  bb_strobe_t       strobe;
  logic             replyStalled;
  logic [PIN_W-1:0] pins;

  bb_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .replyStalled(replyStalled), .newSession(newSession),
    .inReady(inReady), .sessionDone(sessionDone), .strobe(strobe)
  );

  bb_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tdoI(tdoI),
    .outReady(outReady), .pins(pins), .tapRstO(tapRstO), .ledO(ledO),
    .badCmd(badCmd), .outData(outData), .outValid(outValid),
    .replyStalled(replyStalled)
  );

  assign tckO = pins[2];
  assign tmsO = pins[1];
  assign tdiO = pins[0];
endmodule

// File: rtl/bb_checker.sv
module bb_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] inData,
  input logic       inValid,
  input logic       inReady,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       outReady,
  input logic       newSession,
  input logic       tdoI,
  input logic       tckO,
  input logic       tmsO,
  input logic       tdiO,
  input logic       tapRstO,
  input logic       sessionDone,
  input logic       ledO,
  input logic       badCmd
);
  logic live;
  logic isDigit;
  assign live    = inValid && inReady && !sessionDone;
  assign isDigit = inData[7:3] == 5'b00110;

  AST_PIN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (live && isDigit) |=> {tckO, tmsO, tdiO} == $past(inData[2:0])); // R1

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(live && isDigit) |=> $stable({tckO, tmsO, tdiO})); // R2

  AST_REPLY_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (live && inData == 8'h52) |=> outValid && outData == ($past(tdoI) ? 8'h31 : 8'h30)); // R3

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    tapRstO |=> !tapRstO || $past(live && inData == 8'h72)); // R4

  AST_NO_READ_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !sessionDone && inData == 8'h52) |-> !inReady); // R5

  AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outData)); // R5

  AST_DONE_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    sessionDone |-> inReady); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    sessionDone |=> !badCmd && !tapRstO && $stable(ledO)); // R6
endmodule

bind bitbang_cmd_decoder bb_checker i_chk (
  .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
  .inReady(inReady), .outData(outData), .outValid(outValid),
  .outReady(outReady), .newSession(newSession), .tdoI(tdoI),
  .tckO(tckO), .tmsO(tmsO), .tdiO(tdiO), .tapRstO(tapRstO),
  .sessionDone(sessionDone), .ledO(ledO), .badCmd(badCmd)
);

// File: tb/test_bitbang_cmd_decoder.sv
`timescale 1ns/1ps
module test_bitbang_cmd_decoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] outData;
  logic       outValid;
  logic       outReady = 1'b1;
  logic       newSession = 1'b0;
  logic       tdoI = 1'b0;
  logic       tckO, tmsO, tdiO, tapRstO, sessionDone, ledO, badCmd;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [2:0] mPins = 3'd0;
  logic       mLed  = 1'b0;

  always #4 clk = ~clk;

  bitbang_cmd_decoder i_bitbang_cmd_decoder (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .inReady(inReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .newSession(newSession), .tdoI(tdoI),
    .tckO(tckO), .tmsO(tmsO), .tdiO(tdiO), .tapRstO(tapRstO),
    .sessionDone(sessionDone), .ledO(ledO), .badCmd(badCmd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // presents a byte, waits until taken, returns at the negedge after the accepting edge
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inData = b; inValid = 1'b1;
    #1;
    while (!inReady) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  function automatic logic isDigit(input logic [7:0] b);
    return b >= 8'h30 && b <= 8'h37;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 reset state
    chk("R2 pins", {tckO, tmsO, tdiO}, 3'd0);
    chk("R2 led", ledO, 0);
    chk("R2 outValid", outValid, 0);
    chk("R2 tapRst", tapRstO, 0);
    chk("R2 badCmd", badCmd, 0);
    chk("R2 done", sessionDone, 0);
    rstN = 1'b1;

    // sweep every byte value from a known pin state (R1 R3 R4 R6 R7 R8 R9)
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b = v[7:0];
      logic [2:0] pre = 3'(v + 3);
      sendByte({5'b00110, pre});
      mPins = pre;
      chk("R1 preset", {tckO, tmsO, tdiO}, mPins);
      tdoI = b[3];
      sendByte(b);
      if (isDigit(b)) mPins = b[2:0];
      if (b == 8'h42) mLed = 1'b1;
      if (b == 8'h62) mLed = 1'b0;
      chk("R1 R9 pins", {tckO, tmsO, tdiO}, mPins);
      chk("R7 led", ledO, mLed);
      chk("R4 tapRst", tapRstO, b == 8'h72);
      chk("R8 badCmd", badCmd,
          !(isDigit(b) || b == 8'h52 || b == 8'h72 || b == 8'h51 || b == 8'h42 || b == 8'h62));
      chk("R3 outValid", outValid, b == 8'h52);
      if (b == 8'h52) chk("R3 outData", outData, b[3] ? 8'h31 : 8'h30);
      chk("R6 done", sessionDone, b == 8'h51);
      @(negedge clk);
      chk("R4 R8 pulse end", {tapRstO, badCmd}, 2'b00);
      chk("R3 drained", outValid, 0);
      if (b == 8'h51) begin
        // R6 bytes after quit are taken and discarded
        sendByte(8'h30 | {5'd0, ~mPins});
        chk("R6 pins kept", {tckO, tmsO, tdiO}, mPins);
        sendByte(8'h52);
        chk("R6 no reply", outValid, 0);
        sendByte(8'h42);
        chk("R6 led kept", ledO, mLed);
        sendByte(8'hFF);
        chk("R6 no bad", badCmd, 0);
        @(negedge clk); newSession = 1'b1;
        @(negedge clk); newSession = 1'b0;
        chk("R6 cleared", sessionDone, 0);
      end
    end

    // R5 stalled reply blocks a second read
    outReady = 1'b0;
    tdoI = 1'b1;
    sendByte(8'h52);
    chk("R5 first reply valid", outValid, 1);
    chk("R5 first reply", outData, 8'h31);
    sendByte(8'h36);
    chk("R5 digit while stalled", {tckO, tmsO, tdiO}, 3'd6);
    @(negedge clk);
    inData = 8'h52; inValid = 1'b1; tdoI = 1'b0;
    #1 chk("R5 read held back", inReady, 0);
    @(posedge clk); @(negedge clk);
    chk("R5 reply held", outData, 8'h31);
    chk("R5 valid held", outValid, 1);
    outReady = 1'b1;
    #1 chk("R5 read released", inReady, 1);
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    chk("R5 back-to-back valid", outValid, 1);
    chk("R5 second reply", outData, 8'h30);
    @(negedge clk);
    chk("R5 drained", outValid, 0);

    // R9 back-to-back transfers
    @(negedge clk);
    inData = 8'h35; inValid = 1'b1;
    @(negedge clk);
    chk("R9 first", {tckO, tmsO, tdiO}, 3'd5);
    inData = 8'h32;
    @(negedge clk);
    inValid = 1'b0;
    chk("R9 second", {tckO, tmsO, tdiO}, 3'd2);

    summary();
  end
endmodule